// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a true dual-port memory and decides, cycle by cycle, which port keeps access when both ports are enabled on the same word. Each port presents an active-low chip enable, an address and an active-low write strobe. The arbiter returns an active-low busy flag per port and a gated active-low write enable that goes to the RAM. Contention is judged on address equality alone, so it covers reads as well as writes.

Arrival order is judged per clock cycle. A port is "settled" when it was already enabled on the same address in the previous cycle. When contention begins, the settled port wins. When neither port is settled, the left port wins. The winner is held in a register for as long as the contention lasts. The busy flags and the write gating are combinational on the current inputs and that registered state, so they respond in the cycle the contention appears or ends.

A mode input selects the role. In master mode the arbiter drives its own busy outputs and gates the losing port's writes. In slave mode it drives both busy outputs high and gates each port's write from a busy input supplied by a master. A blocked write is dropped, not stored: the port must repeat the write after its busy flag returns high. All pins are plain control signals with no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dp_contention_arb`

## Requirements
- R1: When the two ports are not both enabled on equal addresses, both busy outputs are high (inactive) in master mode.
- R2: In master mode, if the right port was already enabled on the address in the prior cycle and the left port newly reaches it, the left busy output goes low in that same cycle.
- R3: In master mode, if the left port was settled on the address and the right port newly moves onto it, the right busy output goes low in that same cycle.
- R4: In master mode, if both ports arrive on the same address in the same cycle, or if neither was settled, the left port wins and the right busy output goes low.
- R5: While contention persists, the winner recorded when it began stays unchanged, even after both ports have become settled.
- R6: Busy is released in the same cycle that the addresses differ or that either chip enable goes high.
- R7: A chip enable going low onto an address the other enabled port already holds makes that newly enabled port the loser.
- R8: Contention and busy do not depend on the write strobes: two reads of one word raise busy in the same way.
- R9: In master mode, a write on the port whose busy output is low is blocked (its RAM write enable stays high), while the winning port's write passes.
- R10: In slave mode, both busy outputs are high, and each port's RAM write enable is blocked exactly while that port's busy input is low.
- R11: A port's RAM write enable is low only when its chip enable and write strobe are both low and it is not blocked.
- R12: Reset clears the recorded winner and the arrival history, so contention present right after reset is resolved to the left port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = master (busy driven), 0 = slave (busy taken from inputs) |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_we_n | input | 1 | Left write strobe, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_we_n | input | 1 | Right write strobe, active low |
| l_busy_in_n | input | 1 | Left busy from a master, used in slave mode |
| r_busy_in_n | input | 1 | Right busy from a master, used in slave mode |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_busy_out_n | output | 1 | Right busy flag, active low |
| l_ram_we_n | output | 1 | Gated left write enable to the RAM |
| r_ram_we_n | output | 1 | Gated right write enable to the RAM |

## Verification
The vector walk creates contention in four ways: the right address moving onto a settled left port, the left address moving onto a settled right port, a chip enable falling onto an address that already matches, and both ports arriving at once. Each pattern has a different expected winner, so a design that ignored history, or that always favoured one side, fails at least one of them. Held contention with both ports settled separates a registered winner from one recomputed every cycle. Releases by address change and by either enable rising, together with read-only and write attempts under master and slave mode, separate the busy logic from the write gating.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpa_port_track.sv
// Per-port arrival history: a port is settled when it was enabled on the
// same address in the previous cycle as well as in this one.
module dpa_port_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              enabled,
  output logic              settled
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  assign enabled = ~ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= enabled;
      addr_q <= addr;
    end
  end

  assign settled = enabled && en_q && (addr == addr_q);

  // R12: history is empty in the first cycle after reset
  a_r12_history_clear: assert property (@(posedge clk)
    !rst_n |=> !settled);
endmodule

// File: rtl/dpa_owner_fsm.sv
// Holds the winner of a contention episode. owner_now is the decision for
// the current cycle; it is registered so that the grant never flips.
module dpa_owner_fsm
  import dpa_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   match,
  input  logic   l_settled,
  input  logic   r_settled,
  output owner_e owner_now
);
  owner_e owner_q;

  always_comb begin
    if (!match)
      owner_now = OWN_NONE;
    else if (owner_q != OWN_NONE)
      owner_now = owner_q;
    else if (r_settled && !l_settled)
      owner_now = OWN_RIGHT;
    else
      owner_now = OWN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_now;
  end

  // R5: a granted owner survives while contention lasts
  a_r5_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_now != OWN_NONE) ##1 match |-> owner_now == $past(owner_now));
  // R6: without a match nothing is owned in the next cycle's register
  a_r6_owner_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> owner_q == OWN_NONE);
endmodule

// File: rtl/dpa_busy_route.sv
// Turns the ownership decision into busy flags and write gating, per mode.
module dpa_busy_route
  import dpa_pkg::*;
(
  input  logic   master_mode,
  input  owner_e owner_now,
  input  logic   l_en,
  input  logic   r_en,
  input  logic   l_we_n,
  input  logic   r_we_n,
  input  logic   l_busy_in_n,
  input  logic   r_busy_in_n,
  output logic   l_busy_out_n,
  output logic   r_busy_out_n,
  output logic   l_ram_we_n,
  output logic   r_ram_we_n
);
  logic l_lose, r_lose;
  logic l_block, r_block;

  assign l_lose = (owner_now == OWN_RIGHT);
  assign r_lose = (owner_now == OWN_LEFT);

  assign l_busy_out_n = master_mode ? ~l_lose : 1'b1;
  assign r_busy_out_n = master_mode ? ~r_lose : 1'b1;

  assign l_block = master_mode ? l_lose : ~l_busy_in_n;
  assign r_block = master_mode ? r_lose : ~r_busy_in_n;

  assign l_ram_we_n = ~(l_en && !l_we_n && !l_block);
  assign r_ram_we_n = ~(r_en && !r_we_n && !r_block);

  // R9 / R10: a blocked port never writes (immediate checks)
  always_comb begin
    a_r9_left_gate:  assert (!(l_block && !l_ram_we_n));
    a_r9_right_gate: assert (!(r_block && !r_ram_we_n));
  end
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we_n,
  input  logic              r_ce_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we_n,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_out_n,
  output logic              r_busy_out_n,
  output logic              l_ram_we_n,
  output logic              r_ram_we_n
);
  localparam int NPORT = 2;

  logic              ce_n_v [NPORT];
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic              en_v   [NPORT];
  logic              set_v  [NPORT];

  assign ce_n_v[0] = l_ce_n;
  assign ce_n_v[1] = r_ce_n;
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n_v[p]),
      .addr    (addr_v[p]),
      .enabled (en_v[p]),
      .settled (set_v[p])
    );
  end

  logic   match;
  owner_e owner_now;

  assign match = en_v[0] && en_v[1] && (l_addr == r_addr);

  dpa_owner_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .l_settled (set_v[0]),
    .r_settled (set_v[1]),
    .owner_now (owner_now)
  );

  dpa_busy_route u_route (
    .master_mode  (master_mode),
    .owner_now    (owner_now),
    .l_en         (en_v[0]),
    .r_en         (en_v[1]),
    .l_we_n       (l_we_n),
    .r_we_n       (r_we_n),
    .l_busy_in_n  (l_busy_in_n),
    .r_busy_in_n  (r_busy_in_n),
    .l_busy_out_n (l_busy_out_n),
    .r_busy_out_n (r_busy_out_n),
    .l_ram_we_n   (l_ram_we_n),
    .r_ram_we_n   (r_ram_we_n)
  );

  // R1: no shared enabled address means no busy
  a_r1_idle_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_ce_n && !r_ce_n && l_addr == r_addr) |-> l_busy_out_n && r_busy_out_n);
  // R4: at most one side is ever told it lost
  a_r4_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_out_n || r_busy_out_n);
  // R10: slave mode never drives busy low
  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> l_busy_out_n && r_busy_out_n);
  // R5: an unchanged contention keeps the same loser
  a_r5_loser_stable: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && $past(rst_n) && $past(master_mode) && $stable(l_addr)
      && $stable(r_addr) && $stable(l_ce_n) && $stable(r_ce_n)
      |-> $stable(l_busy_out_n) && $stable(r_busy_out_n));
  // R11: a disabled port never writes
  a_r11_disabled_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce_n |-> l_ram_we_n) and (r_ce_n |-> r_ram_we_n));
endmodule

// File: tb/dp_contention_arb_test.sv
module dp_contention_arb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_mode = 1'b1;
  logic        l_ce_n = 1'b1, r_ce_n = 1'b1;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic        l_we_n = 1'b1, r_we_n = 1'b1;
  logic        l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic        l_busy_out_n, r_busy_out_n, l_ram_we_n, r_ram_we_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dp_contention_arb #(.ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce_n(l_ce_n), .l_addr(l_addr), .l_we_n(l_we_n),
    .r_ce_n(r_ce_n), .r_addr(r_addr), .r_we_n(r_we_n),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
    .l_ram_we_n(l_ram_we_n), .r_ram_we_n(r_ram_we_n)
  );

  typedef struct packed {
    logic        mst;
    logic        lce;
    logic [11:0] la;
    logic        lwe;
    logic        rce;
    logic [11:0] ra;
    logic        rwe;
    logic        lbi;
    logic        rbi;
    logic [3:0]  exp;   // {l_busy_out_n, r_busy_out_n, l_ram_we_n, r_ram_we_n}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 12'h123, 1'b1, 1'b1, 12'h456, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd1},  // R1 both off
    '{1'b1, 1'b0, 12'h123, 1'b1, 1'b0, 12'h456, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd1},  // R1 differ
    '{1'b1, 1'b0, 12'h123, 1'b1, 1'b0, 12'h123, 1'b1, 1'b1, 1'b1, 4'b1011, 4'd3},  // R3 R8 read
    '{1'b1, 1'b0, 12'h123, 1'b0, 1'b0, 12'h123, 1'b0, 1'b1, 1'b1, 4'b1001, 4'd9},  // R9 right gated
    '{1'b1, 1'b0, 12'h123, 1'b0, 1'b0, 12'h456, 1'b0, 1'b1, 1'b1, 4'b1100, 4'd6},  // R6 addr differ
    '{1'b1, 1'b0, 12'h456, 1'b1, 1'b0, 12'h456, 1'b1, 1'b1, 1'b1, 4'b0111, 4'd2},  // R2
    '{1'b1, 1'b0, 12'h456, 1'b1, 1'b0, 12'h456, 1'b1, 1'b1, 1'b1, 4'b0111, 4'd5},  // R5 hold
    '{1'b1, 1'b0, 12'h456, 1'b0, 1'b0, 12'h456, 1'b0, 1'b1, 1'b1, 4'b0110, 4'd9},  // R9 left gated
    '{1'b1, 1'b1, 12'h456, 1'b0, 1'b0, 12'h456, 1'b0, 1'b1, 1'b1, 4'b1110, 4'd11}, // R6 R11 lce off
    '{1'b1, 1'b0, 12'h456, 1'b1, 1'b0, 12'h456, 1'b1, 1'b1, 1'b1, 4'b0111, 4'd7},  // R7 ce onto match
    '{1'b1, 1'b0, 12'h456, 1'b1, 1'b1, 12'h456, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd6},  // R6 rce off
    '{1'b1, 1'b1, 12'h123, 1'b1, 1'b1, 12'h789, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd1},  // R1
    '{1'b1, 1'b0, 12'h789, 1'b1, 1'b0, 12'h789, 1'b1, 1'b1, 1'b1, 4'b1011, 4'd4},  // R4 same cycle
    '{1'b1, 1'b1, 12'h789, 1'b1, 1'b1, 12'h789, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd6},  // R6 both off
    '{1'b0, 1'b0, 12'h123, 1'b0, 1'b0, 12'h123, 1'b0, 1'b1, 1'b1, 4'b1100, 4'd10}, // R10 slave free
    '{1'b0, 1'b0, 12'h123, 1'b0, 1'b0, 12'h123, 1'b0, 1'b0, 1'b1, 4'b1110, 4'd10}, // R10 left held
    '{1'b0, 1'b0, 12'h123, 1'b0, 1'b0, 12'h123, 1'b0, 1'b1, 1'b0, 4'b1101, 4'd10}  // R10 right held
  };

  task automatic check(input logic [3:0] exp, input int req, input string what);
    logic [3:0] act;
    act = {l_busy_out_n, r_busy_out_n, l_ram_we_n, r_ram_we_n};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state (R12)
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(4'b1111, 12, "reset idle");
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      master_mode = TBL[i].mst;
      l_ce_n = TBL[i].lce; l_addr = TBL[i].la; l_we_n = TBL[i].lwe;
      r_ce_n = TBL[i].rce; r_addr = TBL[i].ra; r_we_n = TBL[i].rwe;
      l_busy_in_n = TBL[i].lbi; r_busy_in_n = TBL[i].rbi;
      #1;
      check(TBL[i].exp, int'(TBL[i].req), $sformatf("vector %0d", i));
    end

    // R12: reset during right-won contention; afterwards left wins
    @(negedge clk);
    master_mode = 1'b1; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    l_we_n = 1'b1; r_we_n = 1'b1;
    l_ce_n = 1'b1; r_ce_n = 1'b0; r_addr = 12'hABC; l_addr = 12'hABC;
    @(negedge clk); l_ce_n = 1'b0; #1;
    check(4'b0111, 7, "right settled wins");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; #1;
    check(4'b1011, 12, "first cycle after reset");
    @(negedge clk); #1;
    check(4'b1011, 5, "left held after reset");

    // R8: a write on the winner and a read on the loser
    @(negedge clk); l_we_n = 1'b0; #1;
    check(4'b1001, 8, "winner writes, loser reads");
    // dropped write: loser's strobe passes only once released
    @(negedge clk); l_we_n = 1'b1; r_we_n = 1'b0; #1;
    check(4'b1011, 9, "loser write dropped");
    @(negedge clk); l_addr = 12'h001; #1;
    check(4'b1110, 6, "retry passes after release");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule